// File: doc/BRIEF.md
# Chainable Serial Three-Channel PWM Driver

This block is one link in a daisy chain of LED drivers. It watches a serial data line that is qualified by a serial clock. Each device takes one frame of colour data for itself, then passes the rest of the stream on to the next device. It holds one grey-level word for each of three colour channels and turns each word into a pulse-width-modulated output. The serial clock and data inputs are treated as signals already synchronous to the system clock `clk`. Their rising edges are found by comparing each input with its value one cycle earlier.

A frame is a start bit of 1 followed by 24 data bits, sent most significant bit first: channel 0 first, then channel 1, then channel 2. While the device waits for its start bit or takes in its own 24 bits, it drives 0 on its data output. After that it relays every later bit, one bit per serial clock edge. The upstream controller therefore sends a start bit and 24 bits per device, device by device. A latch strobe copies the newly received words into the active PWM registers. A frame that was only partly received is thrown away.

The controlling FSM has three states:
- HUNT: waits for the start bit. It moves to LOAD on a clock edge that carries a 1.
- LOAD: shifts in 24 bits. It moves to RELAY after the 24th bit.
- RELAY: forwards bits to the next device.

The latch strobe takes any state back to HUNT.

A shared grey-scale counter advances on each rising edge of either the serial clock or a free-running oscillator input. The clock-mode pin picks which one. In linear mode the counter counts 32 levels. In gamma mode it counts 256 levels, and each channel's 8-bit level passes through an inverse-gamma ROM first. The display rate depends only on the selected counting clock, not on how long the chain is. With the oscillator selected, the outputs go on showing the last latched levels after the controller stops sending.

Top module: `pwmchain_top`

## Requirements
- R1: While `rst` is high and on the first clock after it, `pwm_o`, `dout_o` and `dclk_o` are 0 and all active levels are 0.
- R2: In HUNT, a rising serial clock edge with `din_i`=1 enters LOAD. The next 24 sampled bits are shifted MSB first into channel 0, then channel 1, then channel 2. During HUNT and LOAD edges, `dout_o` is driven to 0 one clock after the edge.
- R3: In RELAY, each rising serial clock edge copies `din_i` to `dout_o` one clock later. `dout_o` holds its value between edges.
- R4: `dclk_o` equals `dclk_i` delayed by one clock.
- R5: When `latch_i` is high on a clock edge, the FSM returns to HUNT. Only if the FSM was in RELAY are all three received words copied together into the active levels. A partial frame leaves the active levels unchanged. Latch takes priority over a serial clock edge in the same cycle.
- R6: Each `pwm_o[k]` is registered. In each cycle it is 1 exactly when the counter value before the clock edge was below channel k's mapped level.
- R7: With `lin_mode_i`=1, the mapped level is bits [4:0] of the active word, only counter bits [4:0] are compared, and the counter counts modulo 32.
- R8: With `lin_mode_i`=0, the mapped level is floor(x*x*x/65025) for the 8-bit word x, and the counter counts modulo 256.
- R9: With `osc_mode_i`=0, the counter advances on rising edges of `dclk_i`. With `osc_mode_i`=1, it advances on rising edges of `osc_i`. Without the selected edge, the counter holds.
- R10: With `osc_mode_i`=1, the PWM outputs keep cycling with the last latched levels while `dclk_i` and `din_i` stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dclk_i | input | 1 | Serial clock from the previous stage |
| din_i | input | 1 | Serial data from the previous stage |
| latch_i | input | 1 | Strobe that moves received words to the active levels |
| lin_mode_i | input | 1 | 1: linear 32-level scale, 0: 256-level inverse-gamma scale |
| osc_mode_i | input | 1 | 0: count serial clock edges, 1: count oscillator edges |
| osc_i | input | 1 | Free-running oscillator |
| dclk_o | output | 1 | Regenerated serial clock to the next stage |
| dout_o | output | 1 | Serial data to the next stage |
| pwm_o | output | 3 | PWM outputs, bit k for channel k |

## Verification
The bench builds the block with its default parameters: three channels, 8-bit words and a 5-bit linear scale. With these values a full 256-step gamma period and a full 32-step linear period both fit in a short run, and the ROM endpoints (levels 0 and 255) can be reached directly. The bench sends a complete frame followed by bits meant for the next device, then a deliberately short frame before a latch. After that it switches the counting clock to the oscillator and stops all serial activity, to show that the outputs keep running on their own.

// File: rtl/pwmchain_pkg.sv
package pwmchain_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RELAY = 2'd2
    } rx_state_e;

    // Inverse-gamma curve (cubic) scaled so that full scale maps to full scale.
    function automatic int unsigned inv_gamma(input int unsigned x, input int unsigned w);
        longint unsigned top;
        longint unsigned v;
        top = (longint'(1) << w) - 1;
        v   = (longint'(x) * longint'(x) * longint'(x)) / (top * top);
        return int'(v);
    endfunction

endpackage

// File: rtl/pc_serial_rx.sv
module pc_serial_rx
    import pwmchain_pkg::*;
#(
    parameter int CH = 3,
    parameter int W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dclk_i,
    input  logic                 din_i,
    input  logic                 latch_i,
    output logic                 dclk_o,
    output logic                 dout_o,
    output logic                 rise_o,
    output logic [CH-1:0][W-1:0] lvl_o
);
    localparam int FRAME = CH * W;
    localparam int CW    = $clog2(FRAME);

    rx_state_e        st, st_n;
    logic             dclk_q;
    logic [CW-1:0]    bcnt;
    logic [FRAME-1:0] sh;

    assign rise_o = dclk_i & ~dclk_q;

    always_comb begin
        st_n = st;
        if (latch_i) begin
            st_n = ST_HUNT;
        end else if (rise_o) begin
            unique case (st)
                ST_HUNT:  if (din_i) st_n = ST_LOAD;
                ST_LOAD:  if (bcnt == CW'(FRAME - 1)) st_n = ST_RELAY;
                ST_RELAY: st_n = ST_RELAY;
                default:  st_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_HUNT;
        else     st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q <= 1'b0;
            dclk_o <= 1'b0;
            dout_o <= 1'b0;
            bcnt   <= '0;
            sh     <= '0;
            lvl_o  <= '0;
        end else begin
            dclk_q <= dclk_i;
            dclk_o <= dclk_i;
            if (latch_i) begin
                if (st == ST_RELAY) begin
                    for (int k = 0; k < CH; k++)
                        lvl_o[k] <= sh[FRAME-1-k*W -: W];
                end
            end else if (rise_o) begin
                unique case (st)
                    ST_HUNT: begin
                        bcnt   <= '0;
                        dout_o <= 1'b0;
                    end
                    ST_LOAD: begin
                        sh     <= {sh[FRAME-2:0], din_i};
                        bcnt   <= bcnt + 1'b1;
                        dout_o <= 1'b0;
                    end
                    ST_RELAY: dout_o <= din_i;
                    default:  dout_o <= 1'b0;
                endcase
            end
        end
    end

    AST_QUIET_UNTIL_RELAY: assert property (@(posedge clk) disable iff (rst)
        rise_o && !latch_i && st != ST_RELAY |=> !dout_o); // R2
    AST_RELAY_ECHO: assert property (@(posedge clk) disable iff (rst)
        rise_o && !latch_i && st == ST_RELAY |=> dout_o == $past(din_i)); // R3
    AST_CLK_REGEN_HI: assert property (@(posedge clk) disable iff (rst)
        dclk_i |=> dclk_o); // R4
    AST_CLK_REGEN_LO: assert property (@(posedge clk) disable iff (rst)
        !dclk_i |=> !dclk_o); // R4
    AST_LEVELS_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
        !latch_i |=> $stable(lvl_o)); // R5
    AST_LATCH_TO_HUNT: assert property (@(posedge clk) disable iff (rst)
        latch_i |=> st == ST_HUNT); // R5

endmodule

// File: rtl/pc_gs_counter.sv
module pc_gs_counter #(
    parameter int W  = 8,
    parameter int LW = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dclk_rise_i,
    input  logic         osc_i,
    input  logic         osc_mode_i,
    input  logic         lin_i,
    output logic [W-1:0] cnt_o
);
    logic osc_q;
    logic tick;
    logic [LW-1:0] low_inc;

    assign tick    = osc_mode_i ? (osc_i & ~osc_q) : dclk_rise_i;
    assign low_inc = cnt_o[LW-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q <= 1'b0;
            cnt_o <= '0;
        end else begin
            osc_q <= osc_i;
            if (tick) begin
                if (lin_i) cnt_o <= {{(W-LW){1'b0}}, low_inc};
                else       cnt_o <= cnt_o + 1'b1;
            end
        end
    end

    AST_LIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick && lin_i && cnt_o == W'((1 << LW) - 1) |=> cnt_o == '0); // R7
    AST_GAMMA_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick && !lin_i && cnt_o == '1 |=> cnt_o == '0); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/pc_pwm_chan.sv
module pc_pwm_chan
    import pwmchain_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lin_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] lvl_i,
    output logic         pwm_o
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = W'(inv_gamma(i, W));
    end

    always_ff @(posedge clk) begin
        if (rst)        pwm_o <= 1'b0;
        else if (lin_i) pwm_o <= cnt_i[LW-1:0] < lvl_i[LW-1:0];
        else            pwm_o <= cnt_i < rom[lvl_i];
    end

    AST_LIN_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        lin_i && lvl_i[LW-1:0] == '0 |=> !pwm_o); // R7
    AST_GAMMA_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        !lin_i && lvl_i == '0 |=> !pwm_o); // R8
    AST_GAMMA_FULL_LIT: assert property (@(posedge clk) disable iff (rst)
        !lin_i && lvl_i == '1 && cnt_i != '1 |=> pwm_o); // R6

endmodule

// File: rtl/pwmchain_top.sv
module pwmchain_top #(
    parameter int CH = 3,
    parameter int W  = 8,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dclk_i,
    input  logic          din_i,
    input  logic          latch_i,
    input  logic          lin_mode_i,
    input  logic          osc_mode_i,
    input  logic          osc_i,
    output logic          dclk_o,
    output logic          dout_o,
    output logic [CH-1:0] pwm_o
);
    logic                 dclk_rise;
    logic [CH-1:0][W-1:0] lvl;
    logic [W-1:0]         cnt;

    pc_serial_rx #(.CH(CH), .W(W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .dclk_i  (dclk_i),
        .din_i   (din_i),
        .latch_i (latch_i),
        .dclk_o  (dclk_o),
        .dout_o  (dout_o),
        .rise_o  (dclk_rise),
        .lvl_o   (lvl)
    );

    pc_gs_counter #(.W(W), .LW(LW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .dclk_rise_i (dclk_rise),
        .osc_i       (osc_i),
        .osc_mode_i  (osc_mode_i),
        .lin_i       (lin_mode_i),
        .cnt_o       (cnt)
    );

    for (genvar k = 0; k < CH; k++) begin : g_chan
        pc_pwm_chan #(.W(W), .LW(LW)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .lin_i (lin_mode_i),
            .cnt_i (cnt),
            .lvl_i (lvl[k]),
            .pwm_o (pwm_o[k])
        );
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> pwm_o == '0 && !dout_o && !dclk_o); // R1

endmodule

// File: tb/tb_pwmchain_top.sv
module tb_pwmchain_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dclk_i = 1'b0, din_i = 1'b0, latch_i = 1'b0;
    logic lin_mode_i = 1'b0, osc_mode_i = 1'b0, osc_i = 1'b0;
    logic dclk_o, dout_o;
    logic [2:0] pwm_o;

    pwmchain_top dut (
        .clk(clk), .rst(rst), .dclk_i(dclk_i), .din_i(din_i), .latch_i(latch_i),
        .lin_mode_i(lin_mode_i), .osc_mode_i(osc_mode_i), .osc_i(osc_i),
        .dclk_o(dclk_o), .dout_o(dout_o), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0, n_bad = 0, cyc = 0;
    string tag = "R1";

    // behavioural reference model
    int m_st = 0, m_bc = 0, m_sh = 0, m_cnt = 0;
    int m_act [3] = '{0, 0, 0};
    bit m_dq = 0, m_oq = 0, m_dout = 0, m_dclko = 0;
    bit [2:0] m_pwm = '0;

    function automatic int gam(input int x);
        return (x * x * x) / 65025;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit rise, orise, tick;
        bit [2:0] np;
        cyc++;
        if (rst) begin
            m_st = 0; m_bc = 0; m_sh = 0; m_cnt = 0;
            m_act = '{0, 0, 0};
            m_dq = 0; m_oq = 0; m_dout = 0; m_dclko = 0; m_pwm = '0;
        end else begin
            rise  = dclk_i && !m_dq;
            orise = osc_i && !m_oq;
            for (int k = 0; k < 3; k++) begin
                if (lin_mode_i) np[k] = (m_cnt % 32) < (m_act[k] % 32);
                else            np[k] = m_cnt < gam(m_act[k]);
            end
            m_pwm = np;
            m_dclko = dclk_i;
            if (latch_i) begin
                if (m_st == 2) begin
                    m_act[0] = (m_sh >> 16) & 255;
                    m_act[1] = (m_sh >> 8) & 255;
                    m_act[2] = m_sh & 255;
                end
                m_st = 0;
            end else if (rise) begin
                if (m_st == 0) begin
                    m_dout = 0; m_bc = 0;
                    if (din_i) m_st = 1;
                end else if (m_st == 1) begin
                    m_sh = ((m_sh << 1) | int'(din_i)) & 32'hFFFFFF;
                    m_dout = 0;
                    if (m_bc == 23) m_st = 2;
                    else m_bc++;
                end else begin
                    m_dout = din_i;
                end
            end
            tick = osc_mode_i ? orise : rise;
            if (tick) m_cnt = lin_mode_i ? ((m_cnt % 32) + 1) % 32 : (m_cnt + 1) % 256;
            m_dq = dclk_i;
            m_oq = osc_i;
        end
        #(CLK_PERIOD/4);
        chk(dout_o === m_dout, "dout_o (R2 R3)", int'(dout_o), int'(m_dout));
        chk(dclk_o === m_dclko, "dclk_o (R4)", int'(dclk_o), int'(m_dclko));
        chk(pwm_o === m_pwm, "pwm_o (R6)", int'(pwm_o), int'(m_pwm));
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic sbit(input bit b);
        @(negedge clk); din_i = b; dclk_i = 1'b1;
        @(negedge clk);
        @(negedge clk); dclk_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic sframe(input int v);
        sbit(1'b1);
        for (int i = 23; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic latch();
        @(negedge clk); latch_i = 1'b1;
        @(negedge clk); latch_i = 1'b0;
    endtask

    task automatic idle_dclk(input int n);
        for (int i = 0; i < n; i++) sbit(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(pwm_o == 3'b000, "pwm in reset R1", int'(pwm_o), 0);
        chk(dout_o == 1'b0, "dout in reset R1", int'(dout_o), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(pwm_o == 3'b000 && dclk_o == 1'b0, "outputs after reset R1", int'(pwm_o), 0);

        // own frame then bits for the next stage, gamma mode, serial clock counting
        tag = "R2 R3 R8";
        sframe(32'hC040FF);
        sframe(32'h5A3C81);
        tag = "R5 R8";
        latch();
        idle_dclk(300);

        // partial frame must be discarded
        tag = "R5";
        sbit(1'b1);
        for (int i = 0; i < 10; i++) sbit(1'b1);
        latch();
        idle_dclk(270);

        // linear 32-level mode
        tag = "R7";
        lin_mode_i = 1'b1;
        sframe(32'h13E01F);
        latch();
        idle_dclk(80);

        // oscillator counting with serial input idle
        tag = "R9 R10";
        osc_mode_i = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); osc_i = ~osc_i;
        end
        lin_mode_i = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk); osc_i = ~osc_i;
        end

        // reset again mid-run
        tag = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(pwm_o == 3'b000, "pwm after second reset R1", int'(pwm_o), 0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule